// File: doc/BRIEF.md
# Display Controller Run Control and Interrupt Status

This unit is the software-facing control core of a simple raster display controller. A 32-bit control word, written over a single-cycle register bus, starts and stops the controller, picks the panel type and the load mode, and selects which events may raise the interrupt line. A sticky status word collects event strobes from the raster timing and memory fetch engines. Each status bit has its own clearing rule, and one registered interrupt output summarises them.

Stopping is not immediate. When software clears the enable bit, a three-state machine (`ST_IDLE`, `ST_RUN`, `ST_DRAIN`) lets the frame in progress finish. `ST_IDLE` goes to `ST_RUN` on an enable write. `ST_RUN` goes to `ST_DRAIN` on a disable write. `ST_DRAIN` goes back to `ST_RUN` if enable is written again first. `ST_DRAIN` goes to `ST_IDLE` on the engines' end-of-frame strobe. On that last transition the busy flag falls and the DONE status bit is set in the same clock edge. DONE then stays set until the controller is enabled again.

Top module: `lcd_ctl_status`

## Requirements
- R1: After reset the control word, the status word, `busy_o`, `enable_o` and `irq_o` are all zero.
- R2: The control word sits at byte address 0x00 and the status word at 0x10. Control bit 0 is the enable, bits 6:2 are the interrupt enables, bit 7 selects a TFT panel and bits 21:20 are the load mode (01 palette only, 10 frame only, 00 palette then frame). All other control bits read 0, and any other address reads 0.
- R3: A write that sets the enable bit while it is clear enters `ST_RUN`. `busy_o` and `enable_o` are 1 after that write's clock edge.
- R4: A write that clears the enable bit enters `ST_DRAIN`, and `busy_o` stays 1. On the first `frame_end` strobe in `ST_DRAIN`, `busy_o` falls and status bit 0 (DONE) is set at the same edge. A `frame_end` strobe in `ST_RUN` sets nothing.
- R5: DONE ignores write-1-to-clear. DONE is cleared only by a write that sets the enable bit while it is clear.
- R6: Status bits 1 (vsync), 3 (AC-bias count) and 4 (line match) are cleared by writing 1 to them at 0x10. Writing 0 leaves them unchanged. An event in the same cycle as the clear wins.
- R7: Status bits 2 (sync lost) and 5 (FIFO underflow) ignore write-1-to-clear. They are cleared by a write that clears the enable bit while it is set.
- R8: Status bit 6 (palette loaded) is cleared by write-1-to-clear only when the load mode is 01. In any other load mode it ignores write-1-to-clear and is cleared by a disabling write.
- R9: Interrupt enable mapping: control bit 2 gates vsync, bit 3 gates DONE, bit 4 gates palette loaded and bit 6 gates line match.
- R10: Control bit 5 raises the interrupt while the line-match status bit is clear.
- R11: Sync lost and FIFO underflow raise the interrupt with no enable.
- R12: `irq_o` is registered. It follows a status or enable change one clock later.
- R13: Writing enable again during `ST_DRAIN` returns to `ST_RUN`. A later `frame_end` then neither drops busy nor sets DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| frame_end | input | 1 | End-of-frame strobe from the raster engine |
| ev_vsync | input | 1 | Vertical sync event |
| ev_sync_lost | input | 1 | Sync lost event |
| ev_acb | input | 1 | AC-bias count event |
| ev_line | input | 1 | Line match event |
| ev_fuf | input | 1 | FIFO underflow event |
| ev_pal | input | 1 | Palette load finished event |
| enable_o | output | 1 | Enable bit as written |
| busy_o | output | 1 | Running or draining; engines keep fetching |
| tft_o | output | 1 | Active-matrix panel select |
| load_mode_o | output | 2 | Load mode field |
| irq_o | output | 1 | Registered interrupt |

## Verification
A long random phase, run in palette-only mode with a random enable mask, mixes random event strobes with random write-1-to-clear patterns. This separates set-over-clear priority and per-bit clearing from cross-bit leakage, and it checks the interrupt against a one-cycle-delayed model. Directed sequences then walk the state machine through run, drain, drain-then-re-enable and finish. These separate an immediate stop from a drained stop, and a spurious DONE from a correct one. Other directed cases compare how the error bits and the palette bit clear under frame-only mode, where clearing by write is refused and clearing by disable is required. Three single-event cases cover the inverse line enable and the one-cycle interrupt latency.

// File: rtl/lcd_cs_pkg.sv
package lcd_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    localparam int STAT_W       = 7;
    localparam int SB_DONE      = 0;
    localparam int SB_VSYNC     = 1;
    localparam int SB_SYNC_LOST = 2;
    localparam int SB_ACB       = 3;
    localparam int SB_LINE      = 4;
    localparam int SB_UNDERFLOW = 5;
    localparam int SB_PAL       = 6;

    localparam int IE_W         = 5;
    localparam int CB_EN        = 0;
    localparam int CB_IE_LO     = 2;
    localparam int CB_TFT       = 7;
    localparam int CB_LM_LO     = 20;
    localparam int LM_W         = 2;

    // interrupt-enable vector positions (relative to CB_IE_LO)
    localparam int IE_VSYNC     = 0;
    localparam int IE_DONE      = 1;
    localparam int IE_PAL       = 2;
    localparam int IE_LINE_LOW  = 3;
    localparam int IE_LINE      = 4;

    localparam logic [LM_W-1:0] LM_PAL_ONLY = 2'b01;
endpackage

// File: rtl/lcd_cs_fsm.sv
module lcd_cs_fsm
    import lcd_cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_rise,
    input  logic       en_fall,
    input  logic       frame_end,
    output logic       busy_o,
    output logic       done_set_o
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        done_set_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (en_rise) state_d = ST_RUN;
            ST_RUN:   if (en_fall) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (en_rise) begin
                    state_d = ST_RUN;
                end else if (frame_end) begin
                    state_d    = ST_IDLE;
                    done_set_o = 1'b1;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/lcd_cs_status.sv
module lcd_cs_status
    import lcd_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] w1c_i,
    input  logic              en_rise,
    input  logic              en_fall,
    input  logic              pal_only,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] clr;
    logic              unused_w1c;

    assign unused_w1c = ^{w1c_i[SB_DONE], w1c_i[SB_SYNC_LOST], w1c_i[SB_UNDERFLOW]};

    for (genvar i = 0; i < STAT_W; i++) begin : g_clr
        if (i == SB_DONE) begin : g_done
            assign clr[i] = en_rise;
        end else if (i == SB_SYNC_LOST || i == SB_UNDERFLOW) begin : g_err
            assign clr[i] = en_fall;
        end else if (i == SB_PAL) begin : g_pal
            assign clr[i] = pal_only ? w1c_i[i] : en_fall;
        end else begin : g_w1c
            assign clr[i] = w1c_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= set_i | (stat_q & ~clr);
    end
endmodule

// File: rtl/lcd_cs_irq.sv
module lcd_cs_irq
    import lcd_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [IE_W-1:0]   ie_i,
    output logic              irq_o
);
    logic irq_d;
    logic unused_acb;

    assign unused_acb = stat_i[SB_ACB];

    always_comb begin
        irq_d = (stat_i[SB_VSYNC] & ie_i[IE_VSYNC])
              | (stat_i[SB_DONE]  & ie_i[IE_DONE])
              | (stat_i[SB_PAL]   & ie_i[IE_PAL])
              | (~stat_i[SB_LINE] & ie_i[IE_LINE_LOW])
              | (stat_i[SB_LINE]  & ie_i[IE_LINE])
              | stat_i[SB_SYNC_LOST]
              | stat_i[SB_UNDERFLOW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_d;
    end
endmodule

// File: rtl/lcd_ctl_status.sv
module lcd_ctl_status
    import lcd_cs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_end,
    input  logic              ev_vsync,
    input  logic              ev_sync_lost,
    input  logic              ev_acb,
    input  logic              ev_line,
    input  logic              ev_fuf,
    input  logic              ev_pal,
    output logic              enable_o,
    output logic              busy_o,
    output logic              tft_o,
    output logic [1:0]        load_mode_o,
    output logic              irq_o
);
    logic              en_q;
    logic [IE_W-1:0]   ie_q;
    logic              tft_q;
    logic [LM_W-1:0]   lm_q;
    logic              ctrl_wr, stat_wr;
    logic              en_rise, en_fall;
    logic              done_set;
    logic [STAT_W-1:0] ev_vec, w1c, stat_q;
    logic [DATA_W-1:0] ctrl_word;
    logic              unused_wdata;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
    assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);
    assign en_rise = ctrl_wr &  bus_wdata[CB_EN] & ~en_q;
    assign en_fall = ctrl_wr & ~bus_wdata[CB_EN] &  en_q;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:CB_LM_LO+LM_W], bus_wdata[CB_LM_LO-1:CB_TFT+1],
                            bus_wdata[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ie_q  <= '0;
            tft_q <= 1'b0;
            lm_q  <= '0;
        end else if (ctrl_wr) begin
            en_q  <= bus_wdata[CB_EN];
            ie_q  <= bus_wdata[CB_IE_LO +: IE_W];
            tft_q <= bus_wdata[CB_TFT];
            lm_q  <= bus_wdata[CB_LM_LO +: LM_W];
        end
    end

    lcd_cs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rise    (en_rise),
        .en_fall    (en_fall),
        .frame_end  (frame_end),
        .busy_o     (busy_o),
        .done_set_o (done_set)
    );

    assign ev_vec = {ev_pal, ev_fuf, ev_line, ev_acb, ev_sync_lost, ev_vsync, done_set};
    assign w1c    = stat_wr ? bus_wdata[STAT_W-1:0] : '0;

    lcd_cs_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_vec),
        .w1c_i    (w1c),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .pal_only (lm_q == LM_PAL_ONLY),
        .stat_q   (stat_q)
    );

    lcd_cs_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_q),
        .ie_i   (ie_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        ctrl_word                      = '0;
        ctrl_word[CB_EN]               = en_q;
        ctrl_word[CB_IE_LO +: IE_W]    = ie_q;
        ctrl_word[CB_TFT]              = tft_q;
        ctrl_word[CB_LM_LO +: LM_W]    = lm_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR)      bus_rdata = ctrl_word;
        else if (bus_addr == STAT_ADDR) bus_rdata[STAT_W-1:0] = stat_q;
    end

    assign enable_o    = en_q;
    assign tft_o       = tft_q;
    assign load_mode_o = lm_q;
endmodule

// File: rtl/lcd_ctl_status_chk.sv
module lcd_ctl_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       irq_o,
    input logic       ctrl_en,
    input logic       en_rise,
    input logic       en_fall,
    input logic       ev_sync_lost,
    input logic [6:0] stat_q
);
    // R3
    a_r3_busy_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |-> busy_o);
    // R4
    a_r4_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> $fell(busy_o));
    // R5
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !en_rise) |=> stat_q[0]);
    // R7
    a_r7_err_cleared_by_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && !ev_sync_lost) |=> !stat_q[2]);
    // R11
    a_r11_underflow_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[5] |=> irq_o);
endmodule

bind lcd_ctl_status lcd_ctl_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .ctrl_en      (en_q),
    .en_rise      (en_rise),
    .en_fall      (en_fall),
    .ev_sync_lost (ev_sync_lost),
    .stat_q       (stat_q)
);

// File: tb/lcd_ctl_status_test.sv
module lcd_ctl_status_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [6:0]  ev = 0;   // bit order = status bit order, bit0 drives frame_end
    logic        enable_o, busy_o, tft_o, irq_o;
    logic [1:0]  load_mode_o;
    int          checks = 0, fails = 0;
    logic        finished = 0;

    always #2 clk = ~clk;

    lcd_ctl_status uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_end(ev[0]),
        .ev_vsync(ev[1]), .ev_sync_lost(ev[2]), .ev_acb(ev[3]), .ev_line(ev[4]),
        .ev_fuf(ev[5]), .ev_pal(ev[6]), .enable_o(enable_o), .busy_o(busy_o),
        .tft_o(tft_o), .load_mode_o(load_mode_o), .irq_o(irq_o)
    );

    function automatic logic exp_irq(input logic [6:0] st, input logic [31:0] c);
        logic [4:0] ie = c[6:2];
        return (st[1] & ie[0]) | (st[0] & ie[1]) | (st[6] & ie[2]) |
               (~st[4] & ie[3]) | (st[4] & ie[4]) | st[2] | st[5];
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic pulse(input logic [6:0] e);
        ev = e;
        @(negedge clk);
        ev = 0;
    endtask

    task automatic pulse_wr(input logic [6:0] e, input logic [7:0] a, input logic [31:0] d);
        ev = e; bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        ev = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ctrl, r, wd;
        logic [6:0]  st, pst, e;
        logic        w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h10, d); chk("R1 status", d, 0);
        chk("R1 busy", busy_o, 0); chk("R1 irq", irq_o, 0); chk("R1 enable", enable_o, 0);

        // R2 field layout and masking
        wr(8'h00, 32'hFFFF_FF7E);
        rd(8'h00, d); chk("R2 ctrl readback", d, 32'h0030_007C);
        chk("R2 tft", tft_o, 0); chk("R2 load mode", load_mode_o, 2'b11);
        wr(8'h00, 32'h0010_0080);
        chk("R2 tft set", tft_o, 1);
        rd(8'h04, d); chk("R2 unmapped read", d, 0);

        // random phase: palette-only mode, random enables (R6 R8 R9 R12)
        ctrl = 32'h0010_0000 | ({27'd0, 5'($urandom)} << 2);
        wr(8'h00, ctrl);
        idle(1);
        st = 0; pst = 0;
        for (int i = 0; i < 400; i++) begin
            rd(8'h10, d);
            chk("R6 random status", d, {25'd0, st});
            chk("R12 random irq", irq_o, exp_irq(pst, ctrl));
            r  = $urandom;
            e  = {r[6], 1'b0, r[4], r[3], 1'b0, r[1], 1'b0} & {7{r[9]}};
            w  = r[12];
            wd = $urandom;
            if (w) pulse_wr(e, 8'h10, wd); else pulse(e);
            pst = st;
            st  = (e | (st & ~(w ? wd[6:0] : 7'd0))) & 7'h5A;
        end
        wr(8'h10, 32'h7F);
        rd(8'h10, d); chk("R8 pal-only w1c clears", d, 0);

        // frame-only mode: palette and error bits refuse write-1-to-clear
        wr(8'h00, 32'h0020_0000);
        pulse(7'h40); wr(8'h10, 32'h40);
        rd(8'h10, d); chk("R8 pal kept in frame mode", d, 32'h40);
        pulse(7'h24); wr(8'h10, 32'h24);
        rd(8'h10, d); chk("R7 errors ignore w1c", d, 32'h64);
        chk("R11 error irq without enable", irq_o, 1);

        wr(8'h00, 32'h0020_0001);
        chk("R3 busy", busy_o, 1); chk("R3 enable", enable_o, 1);
        pulse(7'h01);
        rd(8'h10, d); chk("R4 no done while running", d, 32'h64);
        chk("R4 busy while running", busy_o, 1);
        wr(8'h00, 32'h0020_0000);
        rd(8'h10, d); chk("R7 R8 disable clears", d, 0);
        chk("R4 drain busy", busy_o, 1);
        idle(3);
        rd(8'h10, d); chk("R4 drain no done", d, 0);
        chk("R4 drain still busy", busy_o, 1);
        pulse(7'h01);
        rd(8'h10, d); chk("R4 done set", d, 32'h01);
        chk("R4 busy dropped", busy_o, 0);
        wr(8'h10, 32'h01);
        rd(8'h10, d); chk("R5 done ignores w1c", d, 32'h01);
        wr(8'h00, 32'h0020_0008); idle(1);
        chk("R9 done irq", irq_o, 1);
        wr(8'h00, 32'h0020_0009);
        rd(8'h10, d); chk("R5 enable clears done", d, 0);

        // R13 re-enable during drain
        wr(8'h00, 32'h0020_0008);
        wr(8'h00, 32'h0020_0009);
        pulse(7'h01);
        rd(8'h10, d); chk("R13 no done after re-enable", d, 0);
        chk("R13 still busy", busy_o, 1);
        wr(8'h00, 32'h0020_0000);
        pulse(7'h01);
        rd(8'h10, d); chk("R4 second done", d, 32'h01);

        // R10 inverse line enable
        wr(8'h00, 32'h20); idle(1);
        chk("R10 irq while line clear", irq_o, 1);
        pulse(7'h10); idle(1);
        chk("R10 irq drops on line", irq_o, 0);
        wr(8'h00, 32'h40); idle(1);
        chk("R9 line irq", irq_o, 1);
        wr(8'h10, 32'h10); idle(1);
        chk("R6 line cleared irq", irq_o, 0);

        // R6 set wins over clear
        wr(8'h00, 32'h0);
        pulse_wr(7'h02, 8'h10, 32'h02);
        rd(8'h10, d); chk("R6 event beats clear", d & 32'h02, 32'h02);
        wr(8'h10, 32'h00);
        rd(8'h10, d); chk("R6 write 0 keeps", d & 32'h02, 32'h02);
        wr(8'h10, 32'h02);
        rd(8'h10, d); chk("R6 w1c clears", d & 32'h02, 0);

        // R12 one-cycle irq latency
        wr(8'h00, 32'h04); idle(1);
        chk("R12 irq idle", irq_o, 0);
        pulse(7'h02);
        chk("R12 irq not yet", irq_o, 0);
        idle(1);
        chk("R12 irq after one cycle", irq_o, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule